// File: doc/BRIEF.md
# Position Counter with Preset Handshake and Encoder Fault Status

This block holds a wrapping up/down position count that a quadrature front end advances through a step strobe and a direction bit. Software homes the axis through a two-sided handshake. It first writes a preset word into a holding register. It then raises a load command. The counter takes the held word and a completion flag goes high. A second load is refused until software has dropped the command and seen the completion flag fall.

The block also gathers the digital outputs of three open-circuit detectors, one for each encoder track (A, B, C). Each track has an enable bit. A disabled track is masked. The block registers per-track fault flags, an OR of those flags, and a data-invalid status. The data-invalid status also follows an internal-error input, so that a consumer knows the sampled position cannot be trusted.

Top module: `pcf_top`

## Requirements
- R1: After reset the count is 0, the completion flag is 0, all track flags, the combined fault bit and data-invalid are 0, the held preset word is 0, and the track enables are A on (bit 0), B on (bit 1), C off (bit 2).
- R2: A clock edge with `preset_wr` high stores `preset_wdata` in the holding register. A load taken at that same edge uses the word held before the edge.
- R3: At an edge where `load_cmd` is high and `load_done` is low, the count takes the held preset word and `load_done` becomes 1, both visible after that edge.
- R4: While `load_done` is 1, a high `load_cmd` does not reload the count and `load_done` stays 1.
- R5: At an edge where `load_cmd` is low, `load_done` becomes 0, which re-arms the load.
- R6: At an edge with `step_en` high and no load, the count changes by +1 when `step_up` is 1 and by -1 when it is 0, modulo 2^CNT_W. With `step_en` low the count holds.
- R7: A load and a step at the same edge leave the count equal to the preset word.
- R8: A clock edge with `trk_en_wr` high stores `trk_en_wdata` as the enables (bit 0 = A, bit 1 = B, bit 2 = C). A disabled track's detector input is ignored and its flag reads 0.
- R9: Each enabled track's flag equals its detector input sampled at the previous edge.
- R10: `open_any` is 1 exactly when at least one track flag is 1.
- R11: `data_invalid` equals the previous edge's combined fault condition OR `int_err`, registered with the same one-cycle latency as the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_en | input | 1 | Count step strobe from the decoder |
| step_up | input | 1 | Step direction, 1 = up |
| preset_wr | input | 1 | Write strobe for the preset holding register |
| preset_wdata | input | CNT_W | Preset word to store |
| load_cmd | input | 1 | Load command bit from software |
| trk_en_wr | input | 1 | Write strobe for the track enables |
| trk_en_wdata | input | NUM_TRK | New track enables, bit 0 = A |
| trk_open | input | NUM_TRK | Open-circuit detector outputs, bit 0 = A |
| int_err | input | 1 | Internal error indication |
| count | output | CNT_W | Position count |
| load_done | output | 1 | Load completion flag |
| trk_flag | output | NUM_TRK | Per-track open-circuit flags |
| open_any | output | 1 | OR of the track flags |
| data_invalid | output | 1 | Sampled data must be treated as invalid |

## Verification
On every cycle the assertions check the following. The completion flag never falls while the command is held and always falls when the command is low. A held command with no step leaves the count unchanged. A disabled track never shows a flag. The combined bit matches the flags, and data-invalid covers any flagged fault. The bench scenarios are needed for the rest. One is that a write of the preset word at the same edge as a load is not seen by that load. Another is the wrap of the count at both ends under a long mixed step sequence. The bench also sweeps all enable, detector and error combinations against arithmetic expectations.

// File: rtl/pcf_pkg.sv
package pcf_pkg;

   typedef enum logic {
      LD_ARMED = 1'b0,
      LD_DONE  = 1'b1
   } ld_state_e;

   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } dir_e;

   typedef struct packed {
      logic load;
      logic step;
      dir_e dir;
   } cnt_cmd_t;

endpackage

// File: rtl/pcf_preset_ctrl.sv
module pcf_preset_ctrl
   import pcf_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             cmd,
   output logic [CNT_W-1:0] preset_q,
   output logic             load,
   output logic             done
);

   ld_state_e state_q;
   ld_state_e state_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) preset_q <= '0;
      else if (wr) preset_q <= wdata;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         LD_ARMED: if (cmd) state_d = LD_DONE;
         LD_DONE:  if (!cmd) state_d = LD_ARMED;
         default:  state_d = LD_ARMED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= LD_ARMED;
      else        state_q <= state_d;
   end

   assign load = cmd && (state_q == LD_ARMED);
   assign done = (state_q == LD_DONE);

   // R4: a held command keeps the completion flag set
   p_done_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cmd) |=> done);

   // R5: a low command clears the completion flag
   p_done_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd |=> !done);

   // R3: an armed command completes in one edge
   p_done_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!done && cmd) |=> done);

endmodule

// File: rtl/pcf_counter.sv
module pcf_counter
   import pcf_pkg::*;
#(
   parameter int unsigned CNT_W    = 32,
   parameter bit          SATURATE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cnt_cmd_t         cmd,
   input  logic [CNT_W-1:0] preset,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
   localparam logic [CNT_W-1:0] TOP  = '1;
   localparam logic [CNT_W-1:0] ZERO = '0;

   if (CNT_W < 2) begin : g_bad_width
      $error("pcf_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] inc_v;
   logic [CNT_W-1:0] dec_v;

   if (SATURATE) begin : g_sat
      assign inc_v = (count == TOP)  ? count : count + ONE;
      assign dec_v = (count == ZERO) ? count : count - ONE;
   end else begin : g_wrap
      assign inc_v = count + ONE;
      assign dec_v = count - ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        count <= '0;
      else if (cmd.load) count <= preset;
      else if (cmd.step) count <= (cmd.dir == DIR_UP) ? inc_v : dec_v;
   end

   // R3, R7: a load wins and takes the preset word
   p_load_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.load |=> (count == $past(preset)));

   // R6: no load and no step leaves the count alone
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd.load && !cmd.step) |=> $stable(count));

endmodule

// File: rtl/pcf_fault_agg.sv
module pcf_fault_agg #(
   parameter int unsigned          NUM_TRK = 3,
   parameter logic [NUM_TRK-1:0]   EN_RST  = 3'b011
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_wr,
   input  logic [NUM_TRK-1:0] en_wdata,
   input  logic [NUM_TRK-1:0] det,
   input  logic               int_err,
   output logic [NUM_TRK-1:0] flag,
   output logic               any,
   output logic               invalid
);

   if (NUM_TRK < 1) begin : g_bad_trk
      $error("pcf_fault_agg: NUM_TRK must be at least 1");
   end

   logic [NUM_TRK-1:0] en_q;
   logic [NUM_TRK-1:0] masked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= EN_RST;
      else if (en_wr) en_q <= en_wdata;
   end

   for (genvar t = 0; t < NUM_TRK; t++) begin : g_trk
      assign masked[t] = en_q[t] & det[t];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag[t] <= 1'b0;
         else        flag[t] <= masked[t];
      end

      // R8: a disabled track never raises its flag
      p_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !en_q[t] |=> !flag[t]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         any     <= 1'b0;
         invalid <= 1'b0;
      end else begin
         any     <= |masked;
         invalid <= (|masked) | int_err;
      end
   end

   // R10: combined bit tracks the per-track flags
   p_any_r10: assert property (@(posedge clk) disable iff (!rst_n)
      any == (|flag));

   // R11: any flagged fault marks the data invalid
   p_invalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> invalid);

endmodule

// File: rtl/pcf_top.sv
module pcf_top
   import pcf_pkg::*;
#(
   parameter int unsigned        CNT_W    = 32,
   parameter int unsigned        NUM_TRK  = 3,
   parameter logic [NUM_TRK-1:0] EN_RST   = 3'b011,
   parameter bit                 SATURATE = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               step_en,
   input  logic               step_up,
   input  logic               preset_wr,
   input  logic [CNT_W-1:0]   preset_wdata,
   input  logic               load_cmd,
   input  logic               trk_en_wr,
   input  logic [NUM_TRK-1:0] trk_en_wdata,
   input  logic [NUM_TRK-1:0] trk_open,
   input  logic               int_err,
   output logic [CNT_W-1:0]   count,
   output logic               load_done,
   output logic [NUM_TRK-1:0] trk_flag,
   output logic               open_any,
   output logic               data_invalid
);

   logic [CNT_W-1:0] preset_q;
   logic             load;
   cnt_cmd_t         cmd;

   pcf_preset_ctrl #(.CNT_W(CNT_W)) u_preset (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (preset_wr),
      .wdata    (preset_wdata),
      .cmd      (load_cmd),
      .preset_q (preset_q),
      .load     (load),
      .done     (load_done)
   );

   assign cmd.load = load;
   assign cmd.step = step_en;
   assign cmd.dir  = step_up ? DIR_UP : DIR_DOWN;

   pcf_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_counter (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd    (cmd),
      .preset (preset_q),
      .count  (count)
   );

   pcf_fault_agg #(.NUM_TRK(NUM_TRK), .EN_RST(EN_RST)) u_fault (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_wr    (trk_en_wr),
      .en_wdata (trk_en_wdata),
      .det      (trk_open),
      .int_err  (int_err),
      .flag     (trk_flag),
      .any      (open_any),
      .invalid  (data_invalid)
   );

   // R4: a refused command with no step does not move the count
   p_no_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (load_done && load_cmd && !step_en) |=> $stable(count));

endmodule

// File: tb/pcf_top_bench.sv
module pcf_top_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_en = 1'b0;
   logic        step_up = 1'b0;
   logic        preset_wr = 1'b0;
   logic [31:0] preset_wdata = '0;
   logic        load_cmd = 1'b0;
   logic        trk_en_wr = 1'b0;
   logic [2:0]  trk_en_wdata = '0;
   logic [2:0]  trk_open = '0;
   logic        int_err = 1'b0;
   logic [31:0] count;
   logic        load_done;
   logic [2:0]  trk_flag;
   logic        open_any;
   logic        data_invalid;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   pcf_top u_pcf_top (
      .clk(clk), .rst_n(rst_n), .step_en(step_en), .step_up(step_up),
      .preset_wr(preset_wr), .preset_wdata(preset_wdata), .load_cmd(load_cmd),
      .trk_en_wr(trk_en_wr), .trk_en_wdata(trk_en_wdata), .trk_open(trk_open),
      .int_err(int_err), .count(count), .load_done(load_done),
      .trk_flag(trk_flag), .open_any(open_any), .data_invalid(data_invalid)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   initial begin
      logic [31:0] model;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      chk("R1 count", count, 0);
      chk("R1 done", {31'd0, load_done}, 0);
      chk("R1 flags", {29'd0, trk_flag}, 0);
      chk("R1 any", {31'd0, open_any}, 0);
      chk("R1 invalid", {31'd0, data_invalid}, 0);

      // R1 enables: A,B on, C off
      trk_open = 3'b111;
      step();
      chk("R1 reset enables", {29'd0, trk_flag}, 32'd3);
      trk_open = 3'b000;

      // R1 preset register resets to 0
      step_en = 1'b1; step_up = 1'b1;
      repeat (5) step();
      chk("R6 up count", count, 5);
      step_en = 1'b0;
      load_cmd = 1'b1;
      step();
      chk("R1 R3 reset preset loads 0", count, 0);
      chk("R3 done set", {31'd0, load_done}, 1);
      load_cmd = 1'b0;
      step();
      chk("R5 done clear", {31'd0, load_done}, 0);

      // R2: write and load at the same edge uses old value
      preset_wr = 1'b1; preset_wdata = 32'd100; load_cmd = 1'b1;
      step_en = 1'b1; step_up = 1'b1;
      step();
      preset_wr = 1'b0; step_en = 1'b0;
      chk("R2 load uses old word", count, 0);
      step();
      chk("R4 no reload while done", count, 0);
      chk("R4 done held", {31'd0, load_done}, 1);
      load_cmd = 1'b0;
      step();
      chk("R5 re-arm", {31'd0, load_done}, 0);
      load_cmd = 1'b1;
      step();
      chk("R3 load new word", count, 100);

      // R7: load beats step; then held command lets counting go on
      load_cmd = 1'b0;
      preset_wr = 1'b1; preset_wdata = 32'd500;
      step();
      preset_wr = 1'b0;
      load_cmd = 1'b1; step_en = 1'b1; step_up = 1'b1;
      step();
      chk("R7 load priority", count, 500);
      step();
      chk("R4 R6 count while done", count, 501);
      step_up = 1'b0;
      step();
      chk("R6 down count", count, 500);
      step_en = 1'b0; load_cmd = 1'b0;
      step();

      // R6 mixed sweep
      model = 32'd500;
      for (int i = 0; i < 40; i++) begin
         step_en = (i % 3) != 0;
         step_up = (i % 5) < 3;
         step();
         if (step_en) model = step_up ? model + 1 : model - 1;
         chk("R6 sweep", count, model);
      end
      step_en = 1'b0;

      // R6 wrap at both ends
      preset_wr = 1'b1; preset_wdata = 32'hFFFF_FFFF;
      step();
      preset_wr = 1'b0; load_cmd = 1'b1;
      step();
      chk("R3 load top", count, 32'hFFFF_FFFF);
      load_cmd = 1'b0; step_en = 1'b1; step_up = 1'b1;
      step();
      chk("R6 wrap up", count, 0);
      step_up = 1'b0;
      step();
      chk("R6 wrap down", count, 32'hFFFF_FFFF);
      step_en = 1'b0;
      step();
      chk("R6 hold", count, 32'hFFFF_FFFF);

      // R8-R11 exhaustive sweep
      for (int e = 0; e < 8; e++) begin
         trk_en_wr = 1'b1; trk_en_wdata = e[2:0];
         trk_open = 3'b000; int_err = 1'b0;
         step();
         trk_en_wr = 1'b0;
         for (int d = 0; d < 8; d++) begin
            for (int ie = 0; ie < 2; ie++) begin
               logic [2:0] ef;
               trk_open = d[2:0]; int_err = ie[0];
               step();
               ef = e[2:0] & d[2:0];
               chk("R8 R9 flags", {29'd0, trk_flag}, {29'd0, ef});
               chk("R10 any", {31'd0, open_any}, {31'd0, |ef});
               chk("R11 invalid", {31'd0, data_invalid}, {31'd0, (|ef) | ie[0]});
            end
         end
      end
      trk_open = 3'b000; int_err = 1'b0;

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule